// File: doc/BRIEF.md
# Diagnostic Port Write Capture

This block watches an 8-bit ISA-style I/O bus and keeps the most recent byte that the CPU wrote to the diagnostic port at I/O address 080h. Firmware writes progress codes to that port during power-on self test. The block holds the latest code for a display or logging stage further down the line. It also keeps a flag that tells whether any code has arrived since the last bus reset. Consumers use that flag to show a "nothing yet" indication instead of a stale value.

The bus is asynchronous to the block's clock. The write strobe, AEN, the ten address lines and the eight data lines each pass through a two-stage synchronizer. The block finds the strobe's trailing (low-to-high) edge inside the clock domain. The address, AEN and data used for the decision are the synchronized values from one clock before that edge, while the strobe was still low. The bus reset input is active high and acts as the block's synchronous reset.

Top module: `post_port_capture`

## Requirements
- R1: A write is selected only when all ten address lines `bus_addr[9:0]` equal 080h. A write to any other ten-bit address, including 180h, 280h and 380h, leaves `post_code` and `no_code_yet` unchanged.
- R2: A write made while `bus_aen` is 1 is a DMA cycle and is ignored, even at address 080h.
- R3: `bus_iow_n` is active low. A cycle in which it never goes low, such as a read of port 080h, changes nothing.
- R4: The byte is taken at the trailing (rising) edge of `bus_iow_n`. The new value appears on `post_code` by the third rising clock edge after the raw strobe rises, provided address, AEN and data were stable for at least two clocks before that rise.
- R5: While `bus_rst` is 1 at a clock edge, that edge sets `no_code_yet` to 1 and `post_code` to 00h.
- R6: A captured write clears `no_code_yet` to 0. It stays 0 through any later traffic until the next bus reset. Only a captured write clears it.
- R7: Between captured writes, `post_code` holds its value.
- R8: The captured byte is the data present while the strobe was low. Data that changes at the same moment the strobe rises is not taken.
- R9: Back-to-back writes to 080h, separated by only a few clocks of strobe-high time, are each captured, and the last one is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| bus_rst | input | 1 | Bus reset, active high, sampled synchronously |
| bus_addr | input | 10 | I/O address lines A9..A0 |
| bus_aen | input | 1 | Address enable; 1 marks a DMA cycle |
| bus_iow_n | input | 1 | I/O write strobe, active low |
| bus_data | input | 8 | Data lines D7..D0 |
| post_code | output | 8 | Last byte written to port 080h |
| no_code_yet | output | 1 | 1 when no code has been captured since bus reset |

## Verification
The checker confirms on every clock that the held code moves only on a qualified strobe edge, and that it then takes exactly the byte presented by the capture stage. It also confirms that the flag falls only on a capture and never rises outside reset, and that reset leaves the flag set and the code at zero. Only the bench scenarios can show the decode itself: that near-miss addresses, DMA cycles and reads are rejected at the pins, that data changing together with the strobe's rise is not taken, and that closely spaced writes each land.

// File: rtl/postcap_pkg.sv
package postcap_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;

    // One synchronized picture of the bus qualifiers and payload.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              aen;
        logic [DATA_W-1:0] data;
    } bus_snap_t;

    localparam int SNAP_W = $bits(bus_snap_t);

    // Capture event handed from the edge stage to the holding stage.
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_evt_t;

    function automatic logic port_hit(input bus_snap_t s,
                                      input logic [ADDR_W-1:0] port);
        return (s.addr == port) && !s.aen;
    endfunction

endpackage

// File: rtl/postcap_sync.sv
module postcap_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[LAST-1:0], d};
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/postcap_strobe.sv
module postcap_strobe
    import postcap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 10'h080
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      iow_n_s,
    input  bus_snap_t snap_s,
    output logic      strobe_rise,
    output cap_evt_t  evt
);
    logic      iow_n_q;
    bus_snap_t snap_q;

    // Delay by one clock so the qualifiers come from the strobe-low period.
    always_ff @(posedge clk) begin
        if (rst) begin
            iow_n_q <= 1'b1;
            snap_q  <= '0;
        end else begin
            iow_n_q <= iow_n_s;
            snap_q  <= snap_s;
        end
    end

    always_comb begin
        strobe_rise = iow_n_s && !iow_n_q;
        evt.valid   = strobe_rise && port_hit(snap_q, PORT_ADDR);
        evt.data    = snap_q.data;
    end
endmodule

// File: rtl/postcap_hold.sv
module postcap_hold
    import postcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cap_evt_t          evt,
    output logic [DATA_W-1:0] code,
    output logic              empty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= '0;
            empty <= 1'b1;
        end else if (evt.valid) begin
            code  <= evt.data;
            empty <= 1'b0;
        end
    end
endmodule

// File: rtl/post_port_capture.sv
module post_port_capture
    import postcap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR   = 10'h080,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              bus_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_aen,
    input  logic              bus_iow_n,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] post_code,
    output logic              no_code_yet
);
    logic              iow_n_s;
    logic [SNAP_W-1:0] snap_raw;
    logic [SNAP_W-1:0] snap_s_bits;
    bus_snap_t         snap_s;
    logic              strobe_rise;
    cap_evt_t          evt;
    logic              cap_valid;
    logic [DATA_W-1:0] cap_data;

    assign snap_raw = {bus_addr, bus_aen, bus_data};

    postcap_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_iow (
        .clk (clk),
        .rst (bus_rst),
        .d   (bus_iow_n),
        .q   (iow_n_s)
    );

    postcap_sync #(.W(SNAP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk (clk),
        .rst (bus_rst),
        .d   (snap_raw),
        .q   (snap_s_bits)
    );

    assign snap_s = bus_snap_t'(snap_s_bits);

    postcap_strobe #(.PORT_ADDR(PORT_ADDR)) u_strobe (
        .clk         (clk),
        .rst         (bus_rst),
        .iow_n_s     (iow_n_s),
        .snap_s      (snap_s),
        .strobe_rise (strobe_rise),
        .evt         (evt)
    );

    assign cap_valid = evt.valid;
    assign cap_data  = evt.data;

    postcap_hold u_hold (
        .clk   (clk),
        .rst   (bus_rst),
        .evt   (evt),
        .code  (post_code),
        .empty (no_code_yet)
    );
endmodule

// File: rtl/postcap_checker.sv
module postcap_checker (
    input logic       clk,
    input logic       bus_rst,
    input logic [7:0] post_code,
    input logic       no_code_yet,
    input logic       strobe_rise,
    input logic       cap_valid,
    input logic [7:0] cap_data
);
    logic started = 1'b0;
    logic rst_q   = 1'b0;

    always_ff @(posedge clk) begin
        started <= 1'b1;
        rst_q   <= bus_rst;
    end

    // R5: an edge that saw reset leaves the flag set and the code cleared
    always_comb begin
        if (started && rst_q) begin
            p_reset_state_r5: assert (no_code_yet && post_code == 8'h00)
                else $error("reset state wrong");
        end
    end

    p_capture_r4: assert property (@(posedge clk) disable iff (bus_rst)
        cap_valid |=> (post_code == $past(cap_data)) && !no_code_yet);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (bus_rst)
        !no_code_yet |=> !no_code_yet);

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (bus_rst)
        $fell(no_code_yet) |-> $past(cap_valid));

    p_hold_r7: assert property (@(posedge clk) disable iff (bus_rst)
        !cap_valid |=> $stable(post_code));

    p_reject_r2: assert property (@(posedge clk) disable iff (bus_rst)
        (strobe_rise && !cap_valid) |=> $stable(post_code) && $stable(no_code_yet));
endmodule

bind post_port_capture postcap_checker u_chk (
    .clk         (clk),
    .bus_rst     (bus_rst),
    .post_code   (post_code),
    .no_code_yet (no_code_yet),
    .strobe_rise (strobe_rise),
    .cap_valid   (cap_valid),
    .cap_data    (cap_data)
);

// File: tb/post_port_capture_test.sv
module post_port_capture_test;
    logic       clk = 1'b0;
    logic       bus_rst = 1'b1;
    logic [9:0] bus_addr = '0;
    logic       bus_aen = 1'b0;
    logic       bus_iow_n = 1'b1;
    logic [7:0] bus_data = '0;
    logic [7:0] post_code;
    logic       no_code_yet;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_code = 8'h00;
    logic       exp_empty = 1'b1;

    always #5 clk = ~clk;

    post_port_capture uut (
        .clk         (clk),
        .bus_rst     (bus_rst),
        .bus_addr    (bus_addr),
        .bus_aen     (bus_aen),
        .bus_iow_n   (bus_iow_n),
        .bus_data    (bus_data),
        .post_code   (post_code),
        .no_code_yet (no_code_yet)
    );

    function automatic logic selected(input logic [9:0] a, input logic en, input logic wr);
        return wr && (a == 10'h080) && !en;
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req);
        tests++;
        if (post_code !== exp_code || no_code_yet !== exp_empty) begin
            fails++;
            $display("FAIL %s: code=%02h flag=%0b expected code=%02h flag=%0b",
                     req, post_code, no_code_yet, exp_code, exp_empty);
        end
    endtask

    task automatic do_reset();
        bus_rst = 1'b1;
        idle(2);
        exp_code = 8'h00;
        exp_empty = 1'b1;
        check("R5 during reset");
        bus_rst = 1'b0;
        idle(1);
    endtask

    // Sets the bus up, optionally pulses the strobe, then changes data as it rises.
    task automatic bus_cycle(input logic [9:0] a, input logic en, input logic [7:0] d,
                             input logic wr, input logic [7:0] d_after, input int gap);
        bus_addr  = a;
        bus_aen   = en;
        bus_data  = d;
        bus_iow_n = 1'b1;
        idle(2);
        if (wr) bus_iow_n = 1'b0;
        idle(3);
        bus_iow_n = 1'b1;
        bus_data  = d_after;
        idle(gap);
        if (selected(a, en, wr)) begin
            exp_code  = d;
            exp_empty = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0080));
        idle(3);
        do_reset();
        check("R5 reset state");

        // R3: read of 080h (no strobe) changes nothing
        bus_cycle(10'h080, 1'b0, 8'h3C, 1'b0, 8'h3C, 5);
        check("R3 read ignored");

        // R1: upper address bits must match
        bus_cycle(10'h180, 1'b0, 8'h11, 1'b1, 8'h11, 5);
        check("R1 addr 180h ignored");
        bus_cycle(10'h380, 1'b0, 8'h12, 1'b1, 8'h12, 5);
        check("R1 addr 380h ignored");
        bus_cycle(10'h081, 1'b0, 8'h13, 1'b1, 8'h13, 5);
        check("R1 addr 081h ignored");

        // R2: DMA cycle ignored
        bus_cycle(10'h080, 1'b1, 8'h14, 1'b1, 8'h14, 5);
        check("R2 aen high ignored");

        // R4 and R6: first real capture
        bus_cycle(10'h080, 1'b0, 8'hA5, 1'b1, 8'hA5, 5);
        check("R4 capture A5");
        check("R6 flag cleared");

        // R8: data changing with strobe rise is not taken
        bus_cycle(10'h080, 1'b0, 8'h5A, 1'b1, 8'hFF, 5);
        check("R8 data during strobe");

        // R7: other port after capture keeps code
        bus_cycle(10'h2F8, 1'b0, 8'h77, 1'b1, 8'h77, 5);
        check("R7 other port keeps code");

        // R9: back-to-back writes, last wins
        bus_cycle(10'h080, 1'b0, 8'h01, 1'b1, 8'h02, 0);
        bus_cycle(10'h080, 1'b0, 8'h02, 1'b1, 8'h03, 0);
        bus_cycle(10'h080, 1'b0, 8'h03, 1'b1, 8'h00, 5);
        check("R9 back-to-back last wins");

        // R5: reset mid-run, then R6 only a capture clears the flag again
        do_reset();
        check("R5 reset after captures");
        bus_cycle(10'h080, 1'b1, 8'h44, 1'b1, 8'h44, 5);
        check("R6 flag stays set on DMA");
        bus_cycle(10'h080, 1'b0, 8'h00, 1'b1, 8'h00, 5);
        check("R6 zero code clears flag");

        // Random traffic
        for (int i = 0; i < 150; i++) begin
            logic [9:0] a;
            int sel;
            sel = int'($urandom % 4);
            case (sel)
                0: a = 10'h080;
                1: a = 10'h080 | (10'h100 << ($urandom % 2));
                2: a = 10'($urandom);
                default: a = 10'h080 ^ (10'h001 << ($urandom % 8));
            endcase
            bus_cycle(a, ($urandom % 4) == 0, 8'($urandom), ($urandom % 5) != 0,
                      8'($urandom), 5);
            check("R4/R7 random");
        end

        finish_run();
    end
endmodule